// File: doc/BRIEF.md
# Receive Channel Reset Sequencer

This block drives the analog and digital reset lines of a group of serial receiver channels. Each channel's analog reset is held while a reset request is present or the PLL is not reported locked. It is then held for a fixed hold time after those conditions clear. The digital reset follows the analog reset. It is released only after the analog reset has dropped, the channel reports lock to incoming data, and a second hold time has elapsed. Hold times are given in nanoseconds and rounded up to whole cycles of the block clock, using a clock-frequency parameter.

The PLL-lock status passes through a filter that requires the lock to be continuously present before it is believed. All asynchronous status inputs are brought into the clock domain through two-flop synchronizers. A build parameter picks one of two structures. In the first, every channel has its own sequencer and reset request. In the second, a single sequencer serves all channels: its request is the OR of the request bits and its data-lock status is the AND of the channel lock bits. A second parameter sets how the block reacts when data lock is lost after release: it restarts the digital reset (auto), it leaves it alone (manual), or an input pin chooses between the two at run time.

Top module: `rx_reset_seq`

## Requirements
- R1: While `rst_n` is low, every bit of `ana_rst_o` and `dig_rst_o` is 1.
- R2: The analog hold is ANA_CYC = ceil(ANA_NS*CLK_MHZ/1000) cycles. Once the last analog gating condition clears at an input pin, with the PLL filter already settled, `ana_rst_o` falls exactly 2+ANA_CYC clock edges later. The 2 edges are the synchronizer.
- R3: A reset request, or a filtered PLL lock that reads 0, asserts the affected analog and digital resets together. It also reloads both hold counters.
- R4: The digital hold is DIG_CYC = ceil(DIG_NS*CLK_MHZ/1000) cycles. When data lock is present, `dig_rst_o` falls exactly DIG_CYC edges after `ana_rst_o` falls. `dig_rst_o` is 1 whenever `ana_rst_o` is 1.
- R5: The synchronized PLL lock counts as locked only after it has stayed high for LOCK_FILT consecutive cycles, and it drops as soon as it goes low. Shorter high pulses leave the resets asserted. With LOCK_FILT=0 there is no filtering, so the filtered lock follows the synchronized lock.
- R6: In auto policy, a data-lock input that goes low reasserts that sequencer's digital reset 3 edges later and leaves its analog reset low. When lock returns, the digital reset falls 2+DIG_CYC edges after the change at the pin.
- R7: In manual policy, losing data lock after the digital reset has been released has no effect. Before release, data lock is still required.
- R8: POLICY encoding: 0 = auto, 1 = manual, 2 = selected by `manual_i` (1 = manual, 0 = auto).
- R9: With SHARED=0, channel i uses only `rst_req_i[i]` and `data_lock_i[i]`. The other channels' outputs are not affected by those bits.
- R10: With SHARED=1, one sequencer uses the OR of `rst_req_i` and the AND of `data_lock_i`. All channel outputs are identical, so every digital reset stays asserted until all channels are locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, frequency CLK_MHZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_req_i | input | N_CH | Per-channel reset request (OR-ed when SHARED=1) |
| pll_lock_i | input | 1 | PLL lock status, asynchronous |
| data_lock_i | input | N_CH | Per-channel lock-to-data status, asynchronous |
| manual_i | input | 1 | Run-time manual policy select, used when POLICY=2 |
| ana_rst_o | output | N_CH | Analog reset per channel, active high |
| dig_rst_o | output | N_CH | Digital reset per channel, active high |

## Verification
The embedded assertions are checked on every cycle:
- A gating condition forces both resets on the next cycle.
- The digital reset always covers the analog reset.
- The analog reset never falls without its gating having cleared.
- In auto policy a lock loss reasserts the digital reset.
- In manual policy a released digital reset stays released.
- A filtered PLL lock never rises without the raw lock having been high.

The bench scenarios show what the assertions cannot:
- The exact hold lengths, including the round-up of a fractional cycle count.
- The glitch suppression of the PLL filter.
- The separation of channels in per-channel mode.
- The all-channels-locked hold of the shared sequencer as the request and lock patterns change.

// File: rtl/rxrs_pkg.sv
package rxrs_pkg;
  localparam int POL_AUTO   = 0;
  localparam int POL_MANUAL = 1;
  localparam int POL_PORT   = 2;

  // nanoseconds to clock cycles, rounded up
  function automatic int unsigned ns2cyc(input longint unsigned ns,
                                         input longint unsigned mhz);
    longint unsigned prod;
    prod = (ns * mhz + 64'd999) / 64'd1000;
    return int'(prod);
  endfunction
endpackage

// File: rtl/rxrs_sync.sv
module rxrs_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/rxrs_lock_filt.sv
module rxrs_lock_filt #(
  parameter int FILT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_i,
  output logic lock_o
);
  localparam int CW = $clog2(FILT + 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;
  logic          full;

  assign full = (cnt_q == CW'(FILT));

  always_comb begin
    cnt_nx = cnt_q;
    if (!lock_i)   cnt_nx = '0;
    else if (!full) cnt_nx = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  assign lock_o = full & lock_i;

  generate
    if (FILT > 0) begin : g_chk
      // R5: a believed lock needs the raw lock in the previous cycle too
      a_r5_rise_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(lock_i));
    end
  endgenerate
endmodule

// File: rtl/rxrs_chan.sv
module rxrs_chan #(
  parameter int unsigned ANA_CYC = 10,
  parameter int unsigned DIG_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic pll_ok_i,
  input  logic dlock_i,
  input  logic manual_i,
  output logic ana_o,
  output logic dig_o
);
  localparam int AW = $clog2(ANA_CYC + 1);
  localparam int DW = $clog2(DIG_CYC + 1);

  logic [AW-1:0] ana_cnt_q, ana_cnt_nx;
  logic [DW-1:0] dig_cnt_q, dig_cnt_nx;
  logic          gate_a, gate_d;

  assign ana_o  = (ana_cnt_q != '0);
  assign dig_o  = (dig_cnt_q != '0);
  assign gate_a = req_i | ~pll_ok_i;
  // lock loss only matters in auto policy or before release
  assign gate_d = gate_a | ana_o | (~dlock_i & (~manual_i | dig_o));

  always_comb begin
    ana_cnt_nx = ana_cnt_q;
    if (gate_a)     ana_cnt_nx = AW'(ANA_CYC);
    else if (ana_o) ana_cnt_nx = ana_cnt_q - AW'(1);
  end

  always_comb begin
    dig_cnt_nx = dig_cnt_q;
    if (gate_d)     dig_cnt_nx = DW'(DIG_CYC);
    else if (dig_o) dig_cnt_nx = dig_cnt_q - DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ana_cnt_q <= AW'(ANA_CYC);
      dig_cnt_q <= DW'(DIG_CYC);
    end else begin
      ana_cnt_q <= ana_cnt_nx;
      dig_cnt_q <= dig_cnt_nx;
    end
  end

  a_r3_gate_forces_both: assert property (@(posedge clk) disable iff (!rst_n)
    gate_a |=> (ana_o && dig_o));
  a_r4_dig_covers_ana: assert property (@(posedge clk) disable iff (!rst_n)
    ana_o |-> dig_o);
  a_r2_fall_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ana_o) |-> $past(!gate_a));
  a_r6_auto_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual_i && !dlock_i) |=> dig_o);
  a_r7_manual_keeps_release: assert property (@(posedge clk) disable iff (!rst_n)
    (manual_i && !gate_a && !ana_o && !dig_o) |=> !dig_o);
endmodule

// File: rtl/rx_reset_seq.sv
module rx_reset_seq #(
  parameter int N_CH      = 4,
  parameter int CLK_MHZ   = 250,
  parameter int ANA_NS    = 40,
  parameter int DIG_NS    = 4000,
  parameter int LOCK_FILT = 4,
  parameter int SHARED    = 0,
  parameter int POLICY    = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] rst_req_i,
  input  logic            pll_lock_i,
  input  logic [N_CH-1:0] data_lock_i,
  input  logic            manual_i,
  output logic [N_CH-1:0] ana_rst_o,
  output logic [N_CH-1:0] dig_rst_o
);
  import rxrs_pkg::*;

  localparam int unsigned ANA_CYC = ns2cyc(64'(ANA_NS), 64'(CLK_MHZ));
  localparam int unsigned DIG_CYC = ns2cyc(64'(DIG_NS), 64'(CLK_MHZ));
  localparam int SW = 2 * N_CH + 2;

  logic [SW-1:0]   sync_s;
  logic [N_CH-1:0] req_s, lock_s;
  logic            pll_s, man_s, pll_ok, man_eff;

  rxrs_sync #(.W(SW)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({rst_req_i, data_lock_i, pll_lock_i, manual_i}),
    .q_o  (sync_s)
  );

  assign {req_s, lock_s, pll_s, man_s} = sync_s;

  rxrs_lock_filt #(.FILT(LOCK_FILT)) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .lock_i(pll_s),
    .lock_o(pll_ok)
  );

  assign man_eff = (POLICY == POL_PORT) ? man_s : (POLICY == POL_MANUAL);

  generate
    if (SHARED != 0) begin : g_shared
      logic ana_one, dig_one;
      rxrs_chan #(.ANA_CYC(ANA_CYC), .DIG_CYC(DIG_CYC)) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (|req_s),
        .pll_ok_i(pll_ok),
        .dlock_i (&lock_s),
        .manual_i(man_eff),
        .ana_o   (ana_one),
        .dig_o   (dig_one)
      );
      assign ana_rst_o = {N_CH{ana_one}};
      assign dig_rst_o = {N_CH{dig_one}};
    end else begin : g_split
      for (genvar i = 0; i < N_CH; i++) begin : g_ch
        rxrs_chan #(.ANA_CYC(ANA_CYC), .DIG_CYC(DIG_CYC)) u_chan (
          .clk     (clk),
          .rst_n   (rst_n),
          .req_i   (req_s[i]),
          .pll_ok_i(pll_ok),
          .dlock_i (lock_s[i]),
          .manual_i(man_eff),
          .ana_o   (ana_rst_o[i]),
          .dig_o   (dig_rst_o[i])
        );
      end
    end
  endgenerate
endmodule

// File: tb/sim_rx_reset_seq.sv
module sim_rx_reset_seq;
  localparam int N   = 4;
  localparam int MHZ = 250;
  localparam int ANS = 20;
  localparam int DNS = 50;
  localparam int FLT = 3;
  localparam int ANA_C = (ANS * MHZ + 999) / 1000;  // 5
  localparam int DIG_C = (DNS * MHZ + 999) / 1000;  // 13 (rounded up from 12.5)

  logic clk, rst_n, pll, man;
  logic [N-1:0] req, lock, a0, d0, a1, d1;
  int total, bad, k;
  bit done;

  // {req[4], lock[4], manual, u0 ana, u0 dig, u1 ana, u1 dig}
  localparam logic [24:0] VEC [8] = '{
    {4'b0000, 4'b1111, 1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0000},
    {4'b0001, 4'b1111, 1'b0, 4'b0001, 4'b0001, 4'b1111, 4'b1111},
    {4'b0000, 4'b1011, 1'b0, 4'b0000, 4'b0100, 4'b0000, 4'b1111},
    {4'b0000, 4'b1111, 1'b1, 4'b0000, 4'b0000, 4'b0000, 4'b0000},
    {4'b0000, 4'b1011, 1'b1, 4'b0000, 4'b0000, 4'b0000, 4'b0000},
    {4'b0010, 4'b1011, 1'b1, 4'b0010, 4'b0010, 4'b1111, 4'b1111},
    {4'b0000, 4'b1011, 1'b1, 4'b0000, 4'b0000, 4'b0000, 4'b1111},
    {4'b0000, 4'b1111, 1'b1, 4'b0000, 4'b0000, 4'b0000, 4'b0000}
  };

  initial clk = 1'b0;
  always #2 clk = ~clk;

  rx_reset_seq #(.N_CH(N), .CLK_MHZ(MHZ), .ANA_NS(ANS), .DIG_NS(DNS),
                 .LOCK_FILT(FLT), .SHARED(0), .POLICY(2)) u0 (
    .clk(clk), .rst_n(rst_n), .rst_req_i(req), .pll_lock_i(pll),
    .data_lock_i(lock), .manual_i(man), .ana_rst_o(a0), .dig_rst_o(d0));

  rx_reset_seq #(.N_CH(N), .CLK_MHZ(MHZ), .ANA_NS(ANS), .DIG_NS(DNS),
                 .LOCK_FILT(FLT), .SHARED(1), .POLICY(2)) u1 (
    .clk(clk), .rst_n(rst_n), .rst_req_i(req), .pll_lock_i(pll),
    .data_lock_i(lock), .manual_i(man), .ana_rst_o(a1), .dig_rst_o(d1));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; req = '0; lock = '1; pll = 1'b0; man = 1'b0;
    cycles(3);
    // R1: reset state
    check("R1 u0 ana", int'(a0), 15);
    check("R1 u0 dig", int'(d0), 15);
    check("R1 u1 ana", int'(a1), 15);
    check("R1 u1 dig", int'(d1), 15);
    rst_n = 1'b1;
    cycles(10);
    // R5: glitch shorter than the filter
    pll = 1'b1; cycles(2); pll = 1'b0; cycles(12);
    check("R5 glitch keeps ana", int'(a0), 15);
    check("R5 glitch keeps dig", int'(d1), 15);
    // R5/R2: filtered release timing
    pll = 1'b1; k = 0;
    while (a0[0] && k < 200) begin @(negedge clk); k++; end
    check("R5 R2 ana release edges", k, 2 + FLT + ANA_C);
    check("R2 all channels ana", int'(a0), 0);
    k = 0;
    while (d0[0] && k < 200) begin @(negedge clk); k++; end
    check("R4 dig hold edges", k, DIG_C);
    check("R10 u1 dig released", int'(d1), 0);

    // table: steady states under R3 R6 R7 R8 R9 R10
    for (int v = 0; v < 8; v++) begin
      req = VEC[v][24:21]; lock = VEC[v][20:17]; man = VEC[v][16];
      cycles(30);
      check($sformatf("R9 R6 R7 v%0d u0 ana", v), int'(a0), int'(VEC[v][15:12]));
      check($sformatf("R9 R6 R7 R8 v%0d u0 dig", v), int'(d0), int'(VEC[v][11:8]));
      check($sformatf("R10 R3 v%0d u1 ana", v), int'(a1), int'(VEC[v][7:4]));
      check($sformatf("R10 R7 v%0d u1 dig", v), int'(d1), int'(VEC[v][3:0]));
    end

    // R6: auto retrigger timing on channel 1
    man = 1'b0; cycles(5);
    lock[1] = 1'b0; k = 0;
    while (!d0[1] && k < 200) begin @(negedge clk); k++; end
    check("R6 dig reassert edges", k, 3);
    check("R6 ana untouched", int'(a0), 0);
    check("R9 other channels dig", int'(d0), 2);
    lock[1] = 1'b1; k = 0;
    while (d0[1] && k < 200) begin @(negedge clk); k++; end
    check("R6 dig release edges", k, 2 + DIG_C);

    // R3: request on channel 3, then release timing
    req[3] = 1'b1; cycles(5);
    check("R3 u0 ana", int'(a0), 8);
    check("R3 u0 dig", int'(d0), 8);
    check("R10 u1 ana", int'(a1), 15);
    req[3] = 1'b0; k = 0;
    while (a0[3] && k < 200) begin @(negedge clk); k++; end
    check("R2 ana release edges", k, 2 + ANA_C);
    k = 0;
    while (d0[3] && k < 200) begin @(negedge clk); k++; end
    check("R4 dig after ana edges", k, DIG_C);

    // R1: reset asserted mid-operation
    rst_n = 1'b0; cycles(1);
    check("R1 reassert ana", int'(a0), 15);
    check("R1 reassert dig", int'(d1), 15);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule